// File: doc/BRIEF.md
# Big-Endian Load/Store Lane Aligner

This block is the alignment stage between a 32-bit big-endian core's address arithmetic and its data memory. It takes five inputs: a decoded load/store opcode, a base register value, a 16-bit immediate, the old contents of the destination register, and the aligned word already fetched from memory. From these it forms the word address and the per-lane write enables. It also places the store data on the correct byte lanes and produces the value to write back for loads.

Byte offset zero within a word is the most significant lane. The block supports byte, halfword and word accesses, signed and unsigned. It also supports the left and right merge forms, which splice part of a memory word into the old register value or write part of a register into part of a word. Halfword accesses do not fault when misaligned. The block clears the low address bit and uses the half the address falls in.

The unit is purely combinational and holds no state. A caller presents one access with the valid flag high. It then uses `byte_en_o` and `store_data_o` for a masked memory write, or `load_data_o` as the register writeback value.

Top module: `be_lsu_align`

## Requirements
- R1: The effective address is `base_i` plus the sign-extended immediate. `word_addr_o` equals that address with bits 1:0 cleared, and the byte offset k is the address's bits 1:0.
- R2: Opcode 0x20 (signed byte) returns the byte at offset k, sign-extended. Opcode 0x24 (unsigned byte) zero-extends it. Offset 0 is data bits 31:24 and offset 3 is bits 7:0.
- R3: Opcode 0x21 (signed half) and opcode 0x25 (unsigned half) ignore address bit 0. Bit 1 clear selects bits 31:16 and bit 1 set selects bits 15:0. The value is then sign-extended or zero-extended.
- R4: Opcode 0x23 returns the full memory word.
- R5: Opcode 0x22 (left merge load) fills result lanes 0..3-k with memory lanes k..3 and keeps the old register in the remaining low lanes.
- R6: Opcode 0x26 (right merge load) fills result lanes 3-k..3 with memory lanes 0..k and keeps the old register in the remaining high lanes.
- R7: `byte_en_o` bit 3-j enables lane j (bit 3 covers data bits 31:24). Opcode 0x28 writes the register's low byte to lane k only. Opcode 0x29 writes the register's low half to lanes 0-1 when address bit 1 is clear, and to lanes 2-3 when it is set.
- R8: Opcode 0x2b writes the whole register to all four lanes. Opcode 0x2a (left merge store) writes the register's upper 4-k bytes to lanes k..3.
- R9: Opcode 0x2e (right merge store) writes the register's lower k+1 bytes to lanes 0..k.
- R10: When `valid_i` is low, or the opcode is not one of the twelve listed, `byte_en_o` is zero and `load_data_o` equals `rt_old_i`.
- R11: A store leaves `load_data_o` equal to `rt_old_i`, and a load drives `byte_en_o` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| valid_i | input | 1 | An access is presented |
| opcode_i | input | 6 | Major opcode of the access |
| base_i | input | ADDR_W | Base register value |
| imm_i | input | IMM_W | Signed address displacement |
| rt_old_i | input | DATA_W | Old value of the data register |
| mem_rdata_i | input | DATA_W | Aligned memory word at `word_addr_o` |
| word_addr_o | output | ADDR_W | Effective address with low two bits cleared |
| byte_en_o | output | DATA_W/8 | Lane write enables, MSB lane in the top bit |
| store_data_o | output | DATA_W | Store data placed on its lanes |
| load_data_o | output | DATA_W | Register writeback value |

## Verification
The unit holds no state, so a wrong internal signal shows up at the ports in the same evaluation as the input that exposes it. There is no delayed symptom to wait for. A bad offset or a lane-reversed shift shows up as a wrong byte in `load_data_o`, or as a write landing one lane away in the behavioural memory. A wrong sign fill shows only when the selected byte or half has its top bit set, so both polarities of memory data are needed. The merge forms hide errors at offsets where the whole word moves, so every offset 0..3 has to be exercised.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

   localparam int OPC_W = 6;

   localparam logic [OPC_W-1:0] OPC_LD_B   = 6'h20;
   localparam logic [OPC_W-1:0] OPC_LD_H   = 6'h21;
   localparam logic [OPC_W-1:0] OPC_LD_L   = 6'h22;
   localparam logic [OPC_W-1:0] OPC_LD_W   = 6'h23;
   localparam logic [OPC_W-1:0] OPC_LD_BU  = 6'h24;
   localparam logic [OPC_W-1:0] OPC_LD_HU  = 6'h25;
   localparam logic [OPC_W-1:0] OPC_LD_R   = 6'h26;
   localparam logic [OPC_W-1:0] OPC_ST_B   = 6'h28;
   localparam logic [OPC_W-1:0] OPC_ST_H   = 6'h29;
   localparam logic [OPC_W-1:0] OPC_ST_L   = 6'h2a;
   localparam logic [OPC_W-1:0] OPC_ST_W   = 6'h2b;
   localparam logic [OPC_W-1:0] OPC_ST_R   = 6'h2e;

   typedef enum logic [2:0] {
      ACC_NONE  = 3'd0,
      ACC_BYTE  = 3'd1,
      ACC_HALF  = 3'd2,
      ACC_WORD  = 3'd3,
      ACC_LEFT  = 3'd4,
      ACC_RIGHT = 3'd5
   } lsa_acc_e;

   typedef struct packed {
      logic     ld;
      logic     st;
      logic     sext;
      lsa_acc_e acc;
   } lsa_ctl_t;

endpackage

// File: rtl/lsa_addr_gen.sv
module lsa_addr_gen #(
   parameter int ADDR_W    = 32,
   parameter int IMM_W     = 16,
   parameter int LANE_BITS = 2
) (
   input  logic [ADDR_W-1:0]    base_i,
   input  logic [IMM_W-1:0]     imm_i,
   output logic [ADDR_W-1:0]    word_addr_o,
   output logic [LANE_BITS-1:0] offs_o
);
   localparam int EXT_W = ADDR_W - IMM_W;

   logic [ADDR_W-1:0] imm_ext;
   logic [ADDR_W-1:0] eff;

   assign imm_ext     = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
   assign eff         = base_i + imm_ext;
   assign word_addr_o = {eff[ADDR_W-1:LANE_BITS], {LANE_BITS{1'b0}}};
   assign offs_o      = eff[LANE_BITS-1:0];

endmodule

// File: rtl/lsa_decode.sv
module lsa_decode
   import lsa_pkg::*;
(
   input  logic             valid_i,
   input  logic [OPC_W-1:0] opcode_i,
   output lsa_ctl_t         ctl_o
);
   lsa_ctl_t raw;

   always_comb begin
      raw = '{ld: 1'b0, st: 1'b0, sext: 1'b0, acc: ACC_NONE};
      unique case (opcode_i)
         OPC_LD_B:  raw = '{ld: 1'b1, st: 1'b0, sext: 1'b1, acc: ACC_BYTE};
         OPC_LD_BU: raw = '{ld: 1'b1, st: 1'b0, sext: 1'b0, acc: ACC_BYTE};
         OPC_LD_H:  raw = '{ld: 1'b1, st: 1'b0, sext: 1'b1, acc: ACC_HALF};
         OPC_LD_HU: raw = '{ld: 1'b1, st: 1'b0, sext: 1'b0, acc: ACC_HALF};
         OPC_LD_W:  raw = '{ld: 1'b1, st: 1'b0, sext: 1'b0, acc: ACC_WORD};
         OPC_LD_L:  raw = '{ld: 1'b1, st: 1'b0, sext: 1'b0, acc: ACC_LEFT};
         OPC_LD_R:  raw = '{ld: 1'b1, st: 1'b0, sext: 1'b0, acc: ACC_RIGHT};
         OPC_ST_B:  raw = '{ld: 1'b0, st: 1'b1, sext: 1'b0, acc: ACC_BYTE};
         OPC_ST_H:  raw = '{ld: 1'b0, st: 1'b1, sext: 1'b0, acc: ACC_HALF};
         OPC_ST_W:  raw = '{ld: 1'b0, st: 1'b1, sext: 1'b0, acc: ACC_WORD};
         OPC_ST_L:  raw = '{ld: 1'b0, st: 1'b1, sext: 1'b0, acc: ACC_LEFT};
         OPC_ST_R:  raw = '{ld: 1'b0, st: 1'b1, sext: 1'b0, acc: ACC_RIGHT};
         default:   raw = '{ld: 1'b0, st: 1'b0, sext: 1'b0, acc: ACC_NONE};
      endcase
   end

   // An idle slot decodes as nothing at all.
   assign ctl_o = valid_i ? raw : '{ld: 1'b0, st: 1'b0, sext: 1'b0, acc: ACC_NONE};

endmodule

// File: rtl/lsa_load_align.sv
module lsa_load_align
   import lsa_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int LANE_BITS = 2
) (
   input  lsa_ctl_t             ctl_i,
   input  logic [LANE_BITS-1:0] offs_i,
   input  logic [DATA_W-1:0]    mem_i,
   input  logic [DATA_W-1:0]    rt_i,
   output logic [DATA_W-1:0]    res_o
);
   localparam int LANES = DATA_W / 8;
   localparam int HALF  = DATA_W / 2;
   localparam int SH_W  = LANE_BITS + 3;

   // Lane j is the j-th byte from the most significant end.
   logic [LANE_BITS-1:0] lane_rev;
   logic [SH_W-1:0]      sh_l;
   logic [SH_W-1:0]      sh_r;
   logic [SH_W-1:0]      sh_h;
   logic [DATA_W-1:0]    mem_up;
   logic [DATA_W-1:0]    mem_dn;
   logic [DATA_W-1:0]    mem_hd;
   logic [7:0]           sel_b;
   logic [HALF-1:0]      sel_h;
   logic [LANES-1:0]     left_take;
   logic [LANES-1:0]     right_take;
   logic [DATA_W-1:0]    left_res;
   logic [DATA_W-1:0]    right_res;

   assign lane_rev = ~offs_i;
   assign sh_l     = {offs_i, 3'b000};
   assign sh_r     = {lane_rev, 3'b000};
   assign sh_h     = {~offs_i[LANE_BITS-1], {(SH_W-1){1'b0}}};

   assign mem_up = mem_i << sh_l;
   assign mem_dn = mem_i >> sh_r;
   assign mem_hd = mem_i >> sh_h;
   assign sel_b  = mem_dn[7:0];
   assign sel_h  = mem_hd[HALF-1:0];

   // Per-lane splice of the shifted memory word with the old register.
   for (genvar j = 0; j < LANES; j++) begin : g_lane
      localparam int HI = DATA_W - 1 - 8 * j;
      assign left_take[j]  = (LANE_BITS'(j) <= lane_rev);
      assign right_take[j] = (LANE_BITS'(j) >= lane_rev);
      assign left_res[HI -: 8]  = left_take[j]  ? mem_up[HI -: 8] : rt_i[HI -: 8];
      assign right_res[HI -: 8] = right_take[j] ? mem_dn[HI -: 8] : rt_i[HI -: 8];
   end

   always_comb begin
      res_o = rt_i;
      if (ctl_i.ld) begin
         unique case (ctl_i.acc)
            ACC_BYTE:  res_o = {{(DATA_W-8){ctl_i.sext & sel_b[7]}}, sel_b};
            ACC_HALF:  res_o = {{(DATA_W-HALF){ctl_i.sext & sel_h[HALF-1]}}, sel_h};
            ACC_WORD:  res_o = mem_i;
            ACC_LEFT:  res_o = left_res;
            ACC_RIGHT: res_o = right_res;
            default:   res_o = rt_i;
         endcase
      end
   end

endmodule

// File: rtl/lsa_store_align.sv
module lsa_store_align
   import lsa_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int LANE_BITS = 2
) (
   input  lsa_ctl_t             ctl_i,
   input  logic [LANE_BITS-1:0] offs_i,
   input  logic [DATA_W-1:0]    rt_i,
   output logic [DATA_W/8-1:0]  be_o,
   output logic [DATA_W-1:0]    data_o
);
   localparam int LANES = DATA_W / 8;
   localparam int HALF  = DATA_W / 2;
   localparam int SH_W  = LANE_BITS + 3;
   localparam logic [LANES-1:0] ALL_L = '1;
   localparam logic [LANES-1:0] LO_HALF_L = {{(LANES/2){1'b0}}, {(LANES/2){1'b1}}};

   logic [LANE_BITS-1:0] lane_rev;
   logic [SH_W-1:0]      sh_l;
   logic [SH_W-1:0]      sh_r;
   logic [SH_W-1:0]      sh_h;
   logic [LANES-1:0]     lane_en;   // bit j = lane j counted from the MSB end

   assign lane_rev = ~offs_i;
   assign sh_l     = {offs_i, 3'b000};
   assign sh_r     = {lane_rev, 3'b000};
   assign sh_h     = {~offs_i[LANE_BITS-1], {(SH_W-1){1'b0}}};

   always_comb begin
      lane_en = '0;
      data_o  = '0;
      if (ctl_i.st) begin
         unique case (ctl_i.acc)
            ACC_BYTE: begin
               lane_en = LANES'(1) << offs_i;
               data_o  = DATA_W'(rt_i[7:0]) << sh_r;
            end
            ACC_HALF: begin
               lane_en = offs_i[LANE_BITS-1] ? ~LO_HALF_L : LO_HALF_L;
               data_o  = DATA_W'(rt_i[HALF-1:0]) << sh_h;
            end
            ACC_WORD: begin
               lane_en = ALL_L;
               data_o  = rt_i;
            end
            ACC_LEFT: begin
               lane_en = ALL_L << offs_i;
               data_o  = rt_i >> sh_l;
            end
            ACC_RIGHT: begin
               lane_en = ALL_L >> lane_rev;
               data_o  = rt_i << sh_r;
            end
            default: begin
               lane_en = '0;
               data_o  = '0;
            end
         endcase
      end
   end

   // Lane 0 (the MSB byte) is the top enable bit.
   for (genvar j = 0; j < LANES; j++) begin : g_be
      assign be_o[LANES-1-j] = lane_en[j];
   end

endmodule

// File: rtl/be_lsu_align.sv
module be_lsu_align
   import lsa_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 32,
   parameter int IMM_W  = 16
) (
   input  logic                  valid_i,
   input  logic [OPC_W-1:0]      opcode_i,
   input  logic [ADDR_W-1:0]     base_i,
   input  logic [IMM_W-1:0]      imm_i,
   input  logic [DATA_W-1:0]     rt_old_i,
   input  logic [DATA_W-1:0]     mem_rdata_i,
   output logic [ADDR_W-1:0]     word_addr_o,
   output logic [DATA_W/8-1:0]   byte_en_o,
   output logic [DATA_W-1:0]     store_data_o,
   output logic [DATA_W-1:0]     load_data_o
);
   localparam int LANES     = DATA_W / 8;
   localparam int LANE_BITS = $clog2(LANES);

   if (DATA_W != 32) begin : g_bad_data_w
      $error("be_lsu_align: DATA_W must be 32");
   end
   if (IMM_W < 2 || IMM_W >= ADDR_W) begin : g_bad_imm_w
      $error("be_lsu_align: IMM_W must be at least 2 and below ADDR_W");
   end
   if (ADDR_W <= LANE_BITS) begin : g_bad_addr_w
      $error("be_lsu_align: ADDR_W too small");
   end

   lsa_ctl_t             ctl;
   logic [LANE_BITS-1:0] offs;

   lsa_addr_gen #(
      .ADDR_W    (ADDR_W),
      .IMM_W     (IMM_W),
      .LANE_BITS (LANE_BITS)
   ) u_addr (
      .base_i      (base_i),
      .imm_i       (imm_i),
      .word_addr_o (word_addr_o),
      .offs_o      (offs)
   );

   lsa_decode u_dec (
      .valid_i  (valid_i),
      .opcode_i (opcode_i),
      .ctl_o    (ctl)
   );

   lsa_load_align #(
      .DATA_W    (DATA_W),
      .LANE_BITS (LANE_BITS)
   ) u_ld (
      .ctl_i  (ctl),
      .offs_i (offs),
      .mem_i  (mem_rdata_i),
      .rt_i   (rt_old_i),
      .res_o  (load_data_o)
   );

   lsa_store_align #(
      .DATA_W    (DATA_W),
      .LANE_BITS (LANE_BITS)
   ) u_st (
      .ctl_i  (ctl),
      .offs_i (offs),
      .rt_i   (rt_old_i),
      .be_o   (byte_en_o),
      .data_o (store_data_o)
   );

endmodule

// File: rtl/lsa_chk.sv
module lsa_chk #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 32,
   parameter int IMM_W  = 16
) (
   input logic                  valid_i,
   input logic [5:0]            opcode_i,
   input logic [ADDR_W-1:0]     base_i,
   input logic [IMM_W-1:0]      imm_i,
   input logic [DATA_W-1:0]     rt_old_i,
   input logic [DATA_W-1:0]     mem_rdata_i,
   input logic [ADDR_W-1:0]     word_addr_o,
   input logic [DATA_W/8-1:0]   byte_en_o,
   input logic [DATA_W-1:0]     store_data_o,
   input logic [DATA_W-1:0]     load_data_o
);
   logic [ADDR_W-1:0] gap;
   logic              is_ld;
   logic              is_st;
   logic              known;

   assign gap   = (base_i + {{(ADDR_W-IMM_W){imm_i[IMM_W-1]}}, imm_i}) - word_addr_o;
   assign is_ld = valid_i && (opcode_i inside {6'h20, 6'h21, 6'h22, 6'h23, 6'h24, 6'h25, 6'h26});
   assign is_st = valid_i && (opcode_i inside {6'h28, 6'h29, 6'h2a, 6'h2b, 6'h2e});
   assign known = !$isunknown({valid_i, opcode_i, base_i, imm_i, rt_old_i, mem_rdata_i});

   always_comb begin
      if (known) begin
         AST_WORD_ALIGNED: assert (word_addr_o[1:0] == 2'b00) else $error("word address not aligned"); // R1
         AST_ADDR_SPAN: assert (gap < 4) else $error("word address not below effective address"); // R1
         AST_IDLE_QUIET: assert (valid_i || (byte_en_o == '0 && load_data_o == rt_old_i)) else $error("idle slot not quiet"); // R10
         AST_LOAD_NO_WRITE: assert (!is_ld || byte_en_o == '0) else $error("load enabled a write"); // R11
         AST_STORE_KEEPS_REG: assert (!is_st || load_data_o == rt_old_i) else $error("store changed the register"); // R11
         AST_BYTE_ONE_LANE: assert (!(valid_i && opcode_i == 6'h28) || $onehot(byte_en_o)) else $error("byte store lanes"); // R7
         AST_HALF_TWO_LANES: assert (!(valid_i && opcode_i == 6'h29) || $countones(byte_en_o) == 2) else $error("half store lanes"); // R7
         AST_WORD_STORE_FULL: assert (!(valid_i && opcode_i == 6'h2b) || (byte_en_o == '1 && store_data_o == rt_old_i)) else $error("word store"); // R8
         AST_WORD_LOAD_PASS: assert (!(valid_i && opcode_i == 6'h23) || load_data_o == mem_rdata_i) else $error("word load"); // R4
         AST_UBYTE_ZERO_TOP: assert (!(valid_i && opcode_i == 6'h24) || load_data_o[DATA_W-1:8] == '0) else $error("unsigned byte fill"); // R2
      end
   end

endmodule

bind be_lsu_align lsa_chk #(
   .DATA_W (DATA_W),
   .ADDR_W (ADDR_W),
   .IMM_W  (IMM_W)
) u_chk (.*);

// File: tb/sim_be_lsu_align.sv
module sim_be_lsu_align;

   logic        clk = 1'b0;
   always #10 clk = ~clk;   // 50 MHz

   logic        valid;
   logic [5:0]  opcode;
   logic [31:0] base;
   logic [15:0] imm;
   logic [31:0] rt_old;
   logic [31:0] mem_rdata;
   logic [31:0] word_addr;
   logic [3:0]  byte_en;
   logic [31:0] store_data;
   logic [31:0] load_data;

   logic [31:0] bmem [16];
   assign mem_rdata = bmem[word_addr[5:2]];

   be_lsu_align u0 (
      .valid_i      (valid),
      .opcode_i     (opcode),
      .base_i       (base),
      .imm_i        (imm),
      .rt_old_i     (rt_old),
      .mem_rdata_i  (mem_rdata),
      .word_addr_o  (word_addr),
      .byte_en_o    (byte_en),
      .store_data_o (store_data),
      .load_data_o  (load_data)
   );

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   function automatic bit is_store(input logic [5:0] op);
      return op inside {6'h28, 6'h29, 6'h2a, 6'h2b, 6'h2e};
   endfunction

   function automatic string tag_of(input logic [5:0] op);
      case (op)
         6'h20, 6'h24: return "R2 byte load";
         6'h21, 6'h25: return "R3 half load";
         6'h23:        return "R4 word load";
         6'h22:        return "R5 left merge load";
         6'h26:        return "R6 right merge load";
         6'h28, 6'h29: return "R7 byte/half store";
         6'h2a, 6'h2b: return "R8 word/left store";
         6'h2e:        return "R9 right merge store";
         default:      return "R10 no-op";
      endcase
   endfunction

   function automatic logic [31:0] ref_load(input logic [5:0] op, input int k,
                                            input logic [31:0] m, input logic [31:0] r);
      logic [7:0]  mb [4];
      logic [31:0] res;
      logic [15:0] h;
      int hb;
      for (int j = 0; j < 4; j++) mb[j] = m[31-8*j -: 8];
      hb = k & 2;
      h  = {mb[hb], mb[hb+1]};
      res = r;
      case (op)
         6'h20: res = {{24{mb[k][7]}}, mb[k]};
         6'h24: res = {24'h0, mb[k]};
         6'h21: res = {{16{h[15]}}, h};
         6'h25: res = {16'h0, h};
         6'h23: res = m;
         6'h22: for (int j = 0; j < 4; j++) if (j <= 3 - k) res[31-8*j -: 8] = mb[j+k];
         6'h26: for (int j = 0; j < 4; j++) if (j >= 3 - k) res[31-8*j -: 8] = mb[j-3+k];
         default: res = r;
      endcase
      return res;
   endfunction

   task automatic ref_store(input logic [5:0] op, input int k, input logic [31:0] old,
                            input logic [31:0] r, output logic [3:0] be, output logic [31:0] nw);
      logic [7:0] rb [4];
      for (int j = 0; j < 4; j++) rb[j] = r[31-8*j -: 8];
      be = 4'h0;
      nw = old;
      for (int j = 0; j < 4; j++) begin
         int src;
         src = -1;
         case (op)
            6'h28: if (j == k) src = 3;
            6'h29: if (j == (k & 2)) src = 2; else if (j == (k & 2) + 1) src = 3;
            6'h2b: src = j;
            6'h2a: if (j >= k) src = j - k;
            6'h2e: if (j <= k) src = 3 - k + j;
            default: src = -1;
         endcase
         if (src >= 0) begin
            be[3-j] = 1'b1;
            nw[31-8*j -: 8] = rb[src];
         end
      end
   endtask

   // Present one access, check every output, commit any store to the model memory.
   task automatic run_op(input bit v, input logic [5:0] op, input logic [31:0] b,
                         input logic [15:0] i, input logic [31:0] r,
                         input bit use_lit, input logic [31:0] lit);
      logic [31:0] ea, exp_addr, old, exp_ld, exp_new, bm, merged;
      logic [3:0]  exp_be;
      logic [5:0]  eop;
      int k;
      @(negedge clk);
      valid = v; opcode = op; base = b; imm = i; rt_old = r;
      #4;
      ea       = b + {{16{i[15]}}, i};
      exp_addr = {ea[31:2], 2'b00};
      k        = int'(ea[1:0]);
      old      = bmem[exp_addr[5:2]];
      eop      = v ? op : 6'h3f;
      chk("R1 word address", word_addr, exp_addr);
      exp_ld = ref_load(eop, k, old, r);
      ref_store(eop, k, old, r, exp_be, exp_new);
      chk(is_store(eop) ? "R11 store keeps reg" : tag_of(eop), load_data, exp_ld);
      chk(is_store(eop) ? tag_of(eop) : "R11/R10 no write enable", {28'h0, byte_en}, {28'h0, exp_be});
      for (int j = 0; j < 4; j++) bm[8*j +: 8] = {8{byte_en[j]}};
      merged = (old & ~bm) | (store_data & bm);
      if (is_store(eop)) begin
         chk(tag_of(eop), merged, exp_new);
         bmem[exp_addr[5:2]] = merged;
         if (use_lit) chk(tag_of(eop), merged, lit);
      end else if (use_lit) begin
         chk(tag_of(eop), load_data, lit);
      end
   endtask

   task automatic setw(input logic [31:0] a, input logic [31:0] d);
      bmem[a[5:2]] = d;
   endtask

   localparam logic [31:0] RTV = 32'haabbccdd;

   initial begin
      logic [5:0] ops [12];
      ops = '{6'h20, 6'h21, 6'h22, 6'h23, 6'h24, 6'h25, 6'h26,
              6'h28, 6'h29, 6'h2a, 6'h2b, 6'h2e};
      void'($urandom(32'd1234));
      for (int j = 0; j < 16; j++) bmem[j] = 32'h0;
      valid = 1'b0; opcode = 6'h0; base = 32'h0; imm = 16'h0; rt_old = 32'h0;

      // Idle state
      @(negedge clk);
      #4;
      chk("R10 idle enables", {28'h0, byte_en}, 32'h0);
      chk("R10 idle result", load_data, 32'h0);

      // R2 byte loads, big-endian lanes
      setw(32'h100, 32'h11223344);
      run_op(1, 6'h20, 32'h100, 16'h0001, RTV, 1, 32'h00000022);
      run_op(1, 6'h20, 32'h102, 16'h0000, RTV, 1, 32'h00000033);
      run_op(1, 6'h20, 32'h104, 16'hfffd, RTV, 1, 32'h00000022);  // R1 negative immediate
      setw(32'h100, 32'hf1f2f3f4);
      run_op(1, 6'h20, 32'h103, 16'h0000, RTV, 1, 32'hfffffff4);
      run_op(1, 6'h24, 32'h100, 16'h0000, RTV, 1, 32'h000000f1);
      // R3 halves ignore bit 0
      run_op(1, 6'h21, 32'h100, 16'h0000, RTV, 1, 32'hfffff1f2);
      run_op(1, 6'h21, 32'h101, 16'h0000, RTV, 1, 32'hfffff1f2);
      run_op(1, 6'h21, 32'h102, 16'h0001, RTV, 1, 32'hfffff3f4);
      run_op(1, 6'h25, 32'h100, 16'h0000, RTV, 1, 32'h0000f1f2);
      // R4, R5, R6
      setw(32'h100, 32'h11223344);
      run_op(1, 6'h23, 32'h100, 16'h0000, RTV, 1, 32'h11223344);
      run_op(1, 6'h22, 32'h100, 16'h0000, RTV, 1, 32'h11223344);
      run_op(1, 6'h22, 32'h100, 16'h0001, RTV, 1, 32'h223344dd);
      run_op(1, 6'h22, 32'h100, 16'h0003, RTV, 1, 32'h44bbccdd);
      run_op(1, 6'h26, 32'h100, 16'h0000, RTV, 1, 32'haabbcc11);
      run_op(1, 6'h26, 32'h100, 16'h0001, RTV, 1, 32'haabb1122);
      run_op(1, 6'h26, 32'h100, 16'h0003, RTV, 1, 32'h11223344);
      // R7 byte/half stores
      setw(32'h100, 32'h0); run_op(1, 6'h28, 32'h100, 16'h0001, RTV, 1, 32'h00dd0000);
      setw(32'h100, 32'h0); run_op(1, 6'h28, 32'h103, 16'h0000, RTV, 1, 32'h000000dd);
      setw(32'h100, 32'h0); run_op(1, 6'h29, 32'h100, 16'h0002, RTV, 1, 32'h0000ccdd);
      setw(32'h100, 32'h0); run_op(1, 6'h29, 32'h100, 16'h0003, RTV, 1, 32'h0000ccdd);
      setw(32'h100, 32'h0); run_op(1, 6'h29, 32'h101, 16'h0000, RTV, 1, 32'hccdd0000);
      // R8 word / left stores
      setw(32'h100, 32'h0); run_op(1, 6'h2b, 32'h100, 16'h0000, RTV, 1, 32'haabbccdd);
      setw(32'h100, 32'h0); run_op(1, 6'h2a, 32'h100, 16'h0000, RTV, 1, 32'haabbccdd);
      setw(32'h100, 32'h11223344); run_op(1, 6'h2a, 32'h100, 16'h0002, RTV, 1, 32'h1122aabb);
      // R9 right stores
      setw(32'h100, 32'h0); run_op(1, 6'h2e, 32'h100, 16'h0001, RTV, 1, 32'hccdd0000);
      setw(32'h100, 32'h11223344); run_op(1, 6'h2e, 32'h100, 16'h0003, RTV, 1, 32'haabbccdd);
      // R10 unknown opcode and idle slot leave memory and register alone
      setw(32'h100, 32'h55667788);
      run_op(1, 6'h27, 32'h100, 16'h0000, RTV, 1, RTV);
      run_op(0, 6'h2b, 32'h100, 16'h0000, RTV, 1, RTV);
      chk("R10 memory untouched", bmem[0], 32'h55667788);

      // Constrained random mix
      for (int n = 0; n < 600; n++) begin
         logic [5:0] op;
         int sel;
         if (n % 16 == 0)
            for (int j = 0; j < 16; j++) bmem[j] = $urandom;
         sel = $urandom_range(0, 13);
         op  = (sel < 12) ? ops[sel] : 6'($urandom);
         run_op($urandom_range(0, 9) != 0, op, $urandom, 16'($urandom), $urandom, 0, 32'h0);
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

endmodule